// File: doc/BRIEF.md
# Gated Seven-Decade BCD Event Counter

This block tallies events in decimal. Each clock cycle in which the event input is high while the gate input is high adds one to a chain of BCD decades. When a decade rolls over from nine to zero, it hands a carry to the next decade up within the same cycle, so any run of nines resolves on the very next edge. A clear input returns every decade to zero. It also clears a sticky flag that records a rollover of the most significant decade.

The count itself is not visible at the ports. A separate storage register sits behind the counter and provides the stored value. On every edge where the latch input is high, that register takes in the count. While the latch input stays low, the register holds its contents, even across a clear. A controller therefore opens the gate for a measurement interval and closes it. It then strobes the latch to publish the result, and clears the counter for the next interval. Holding the latch high makes the stored value follow the counter one cycle behind.

Top module: `gated_bcd_tally`

## Requirements
- R1: After reset, `stored_o` is all zeros and `overflow_o` is 0.
- R2: A clock edge where `gate_i` and `event_i` are both high, and `clear_i` is low, raises the count by exactly one. With `gate_i` high and `event_i` low, the count does not change.
- R3: While `gate_i` is low, `event_i` pulses have no effect on the count.
- R4: A decade at 9 that receives an increment goes to 0 and advances the next decade on the same edge. A count of 999 plus one event reads 1000 after that single edge.
- R5: `clear_i` sets every decade to 0 and `overflow_o` to 0 on the next edge. It wins over a simultaneous counted event.
- R6: On each edge where `latch_i` is high, the storage register loads the count held just before that edge. On edges where `latch_i` is low, `stored_o` stays unchanged.
- R7: `clear_i` does not alter `stored_o`.
- R8: An accepted event while every decade holds 9 wraps the count to all zeros and sets `overflow_o`. `overflow_o` then stays 1 until a clear.
- R9: Decade i occupies bits [4i+3:4i] of `stored_o`, with bit weights 1, 2, 4 and 8. The least significant decade is at [3:0], and each nibble only ever holds 0 to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| event_i | input | 1 | Event present this cycle |
| gate_i | input | 1 | Counting window open |
| clear_i | input | 1 | Zero the decades and the overflow flag |
| latch_i | input | 1 | Load the storage register on this edge |
| stored_o | output | 4*NUM_DIGITS (28) | Stored BCD count, least significant decade first |
| overflow_o | output | 1 | Sticky rollover of the top decade |

## Verification
The bench builds two copies from the same stimulus. The first uses the default seven decades and covers counts up to five digits, including rollover chains such as 99 to 100 and 999 to 1000. The second is built with three decades. At that size, a full wrap of the top decade and the sticky overflow flag are reached in about a thousand events, where the default size would need ten million.

// File: rtl/bcd_tally_pkg.sv
package bcd_tally_pkg;
    localparam int BCD_W = 4;
    typedef logic [BCD_W-1:0] bcd_t;
    localparam bcd_t BCD_MAX = 4'd9;

    typedef struct packed {
        bcd_t cnt;
    } digit_state_t;

    typedef struct packed {
        logic ovf;
    } tally_state_t;
endpackage

// File: rtl/bcd_digit.sv
module bcd_digit
    import bcd_tally_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic inc_i,
    output bcd_t cnt_o,
    output logic wrap_o
);
    digit_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i)
            st_d.cnt = '0;
        else if (inc_i)
            st_d.cnt = (st_q.cnt == BCD_MAX) ? bcd_t'(0) : st_q.cnt + bcd_t'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign wrap_o = inc_i && (st_q.cnt == BCD_MAX);

    // R9: a decade never leaves the decimal range
    p_digit_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= BCD_MAX);
    // R5: clear forces zero
    p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> cnt_o == '0);
    // R3: without an increment the decade holds
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !clear_i) |=> $stable(cnt_o));
endmodule

// File: rtl/bcd_store.sv
module bcd_store #(
    parameter int W = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         latch_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o
);
    logic [W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (latch_i) data_d = din_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign dout_o = data_q;

    // R6: load on strobe, hold otherwise
    p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        latch_i |=> dout_o == $past(din_i));
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_i |=> $stable(dout_o));
endmodule

// File: rtl/gated_bcd_tally.sv
module gated_bcd_tally
    import bcd_tally_pkg::*;
#(
    parameter int NUM_DIGITS = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        event_i,
    input  logic                        gate_i,
    input  logic                        clear_i,
    input  logic                        latch_i,
    output logic [NUM_DIGITS*BCD_W-1:0] stored_o,
    output logic                        overflow_o
);
    localparam int CNT_W = NUM_DIGITS * BCD_W;

    logic [NUM_DIGITS:0] carry;
    logic [CNT_W-1:0]    count_w;
    tally_state_t        st_d, st_q;

    assign carry[0] = gate_i & event_i;

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_decade
        bcd_digit u_digit (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (clear_i),
            .inc_i   (carry[g]),
            .cnt_o   (count_w[g*BCD_W +: BCD_W]),
            .wrap_o  (carry[g+1])
        );
    end

    always_comb begin
        st_d = st_q;
        if (clear_i)
            st_d.ovf = 1'b0;
        else if (carry[NUM_DIGITS])
            st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign overflow_o = st_q.ovf;

    bcd_store #(.W(CNT_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .latch_i (latch_i),
        .din_i   (count_w),
        .dout_o  (stored_o)
    );

    // R5: clear drops the overflow flag
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !overflow_o);
    // R8: the flag is sticky
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_o && !clear_i) |=> overflow_o);
    // R8: full wrap empties the count and raises the flag
    p_ovf_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (carry[NUM_DIGITS] && !clear_i) |=> (overflow_o && count_w == '0));
    // R3: closed gate freezes the count
    p_gate_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_i && !clear_i) |=> $stable(count_w));
endmodule

// File: tb/gated_bcd_tally_bench.sv
module gated_bcd_tally_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev = 1'b0, gate = 1'b0, clr = 1'b0, lat = 1'b0;
    logic [27:0] stored;
    logic        ovf;
    logic [11:0] s_stored;
    logic        s_ovf;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gated_bcd_tally u_gated_bcd_tally (
        .clk(clk), .rst_n(rst_n), .event_i(ev), .gate_i(gate),
        .clear_i(clr), .latch_i(lat), .stored_o(stored), .overflow_o(ovf));

    gated_bcd_tally #(.NUM_DIGITS(3)) u_small (
        .clk(clk), .rst_n(rst_n), .event_i(ev), .gate_i(gate),
        .clear_i(clr), .latch_i(lat), .stored_o(s_stored), .overflow_o(s_ovf));

    typedef struct packed {
        logic        clr;
        logic [15:0] n_on;
        logic [15:0] n_off;
        logic [15:0] n_idle;
        logic [27:0] exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b1, 16'd1,     16'd0,  16'd0,  28'h0000001},
        '{1'b0, 16'd8,     16'd5,  16'd3,  28'h0000009},
        '{1'b0, 16'd1,     16'd0,  16'd0,  28'h0000010},
        '{1'b0, 16'd89,    16'd3,  16'd2,  28'h0000099},
        '{1'b0, 16'd901,   16'd0,  16'd0,  28'h0001000},
        '{1'b1, 16'd12345, 16'd7,  16'd4,  28'h0012345},
        '{1'b0, 16'd0,     16'd40, 16'd0,  28'h0012345},
        '{1'b0, 16'd0,     16'd0,  16'd25, 28'h0012345}
    };

    task automatic cyc(input logic g, input logic e, input logic c, input logic l);
        gate = g; ev = e; clr = c; lat = l;
        @(negedge clk);
    endtask

    task automatic snap();
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic check(input string tag, input logic [27:0] act, input logic [27:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check("R1 stored", stored, 28'h0);
        check("R1 overflow", {27'h0, ovf}, 28'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R9 vector walk
        for (int i = 0; i < 8; i++) begin
            if (VECS[i].clr) cyc(1'b0, 1'b0, 1'b1, 1'b0);
            repeat (int'(VECS[i].n_on))   cyc(1'b1, 1'b1, 1'b0, 1'b0);
            repeat (int'(VECS[i].n_off))  cyc(1'b0, 1'b1, 1'b0, 1'b0);
            repeat (int'(VECS[i].n_idle)) cyc(1'b1, 1'b0, 1'b0, 1'b0);
            snap();
            check($sformatf("R2 R3 R4 vector %0d", i), stored, VECS[i].exp);
        end
        // R9 nibble placement
        check("R9 low decade", {24'h0, stored[3:0]}, 28'h5);
        check("R9 decade 4", {24'h0, stored[19:16]}, 28'h1);

        // R6 hold while latch low
        repeat (5) cyc(1'b1, 1'b1, 1'b0, 1'b0);
        check("R6 hold", stored, 28'h0012345);
        snap();
        check("R6 reload", stored, 28'h0012350);

        // R7 clear leaves storage alone
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        check("R7 stored after clear", stored, 28'h0012350);
        check("R5 overflow after clear", {27'h0, ovf}, 28'h0);
        snap();
        check("R5 count cleared", stored, 28'h0);

        // R5 clear beats a simultaneous event
        repeat (3) cyc(1'b1, 1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1'b1, 1'b0);
        snap();
        check("R5 clear priority", stored, 28'h0);

        // R6 latch held high trails the count by one edge
        repeat (4) cyc(1'b1, 1'b1, 1'b0, 1'b1);
        check("R6 trailing", stored, 28'h3);
        snap();
        check("R6 final", stored, 28'h4);

        // R8 on the three-decade copy
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        check("R8 small flag cleared", {27'h0, s_ovf}, 28'h0);
        repeat (999) cyc(1'b1, 1'b1, 1'b0, 1'b0);
        snap();
        check("R8 small at 999", {16'h0, s_stored}, 28'h999);
        check("R8 no flag at 999", {27'h0, s_ovf}, 28'h0);
        check("R4 wide at 999", stored, 28'h0000999);
        cyc(1'b1, 1'b1, 1'b0, 1'b0);
        check("R8 flag set on wrap", {27'h0, s_ovf}, 28'h1);
        snap();
        check("R8 small wrapped", {16'h0, s_stored}, 28'h000);
        check("R4 wide carry to 1000", stored, 28'h0001000);
        check("R8 wide no flag", {27'h0, ovf}, 28'h0);
        repeat (5) cyc(1'b1, 1'b1, 1'b0, 1'b0);
        check("R8 flag sticky", {27'h0, s_ovf}, 28'h1);
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        check("R5 flag cleared", {27'h0, s_ovf}, 28'h0);

        done = 1'b1;
        finish_run();
    end
endmodule